// File: doc/BRIEF.md
# Receive Packet Buffer with Overrun Accounting

This block sits between a receive MAC and the host side of a network controller. The MAC writes packets as sequences of words. The first word of each packet carries the packet's length in words. The block holds each packet in a circular word store and shows it to the host reader only once its final word has been written. A packet reaches the reader whole, or it does not reach the reader at all.

The accept or reject decision is made on the first word of a packet. The declared length is compared with the number of free words. If the packet does not fit, every word of it is swallowed and nothing is written. The drop is recorded in a saturating missed-packet counter, and a sticky overrun cause bit is set, which can raise an interrupt. A small register port lets software do the following:
- enable reception;
- mask the interrupt;
- read the counter and the cause bit, and clear them;
- see how many complete packets are stored;
- inspect the read and write pointers, together with copies of them taken at the last drop.

Top module: `rx_pkt_store`

## Requirements
- R1: A packet whose declared length (`wrLen` on the first beat) is no larger than the free word count is stored whole. It is read back in write order, and `rdEop` is 1 on its last word only.
- R2: While reception is enabled, a packet whose declared length exceeds the free word count writes no word, leaves the tail pointer unchanged, and adds one to the missed counter (register 0).
- R3: Every drop counted under R2 sets the overrun cause bit (register 1, bit 0). The bit stays set until it is cleared.
- R4: While control bit 0 (receive enable, register 2) is 0, incoming packets are discarded, and both the missed counter and the cause bit keep their values.
- R5: The missed counter saturates at all ones, the width being `MISS_W`.
- R6: Reading register 0 returns the counter and clears it. A drop in the same cycle as that read leaves the counter at 1.
- R7: The cause bit clears when register 1 is read, and when a write to register 1 has bit 0 equal to 1. A write with bit 0 equal to 0 leaves it unchanged.
- R8: `irq` is 1 exactly when the cause bit is 1 and control bit 1 (interrupt mask enable) is 1.
- R9: Register 3 holds the number of complete packets stored. It rises when a packet's last word is written and falls when the reader pops a last word. `rdValid` is 1 only while this count is nonzero.
- R10: Register 4 is the read pointer and register 5 is the write position just past the last complete packet, both in words modulo `DEPTH`. Registers 6 and 7 take copies of registers 4 and 5 at each counted drop.
- R11: Receive enable is sampled only on a packet's first beat. A change while the packet is in progress does not alter that packet's fate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | MAC word valid |
| wrSop | input | 1 | First word of a packet |
| wrEop | input | 1 | Last word of a packet |
| wrLen | input | LEN_W | Packet length in words, valid with wrSop |
| wrData | input | DATA_W | MAC word |
| rdPop | input | 1 | Reader consumes the word at the head |
| rdValid | output | 1 | At least one complete packet is stored |
| rdData | output | DATA_W | Word at the head |
| rdEop | output | 1 | Head word ends its packet |
| regAddr | input | 3 | Register select |
| regRd | input | 1 | Read strobe; read side effects take place on the clock edge |
| regWr | input | 1 | Write strobe |
| regWdata | input | 2 | Write data (control or cause-clear bits) |
| regRdata | output | 32 | Read data for regAddr, combinational |
| irq | output | 1 | Masked overrun interrupt |

## Verification
The assertions assume a well-formed MAC stream. Every packet opens with `wrSop` and closes with `wrEop`, its beat count equals the declared `wrLen`, and that length is at least one. The assertions also assume the reader pops only while `rdValid` is 1. The bench drives each packet through a single task that derives the start and end flags from the length it is given. It pops only whole packets that it has seen committed. Oversized packets are always sent with their full declared number of beats.

// File: rtl/rx_pkt_store_pkg.sv
package rx_pkt_store_pkg;

  typedef struct packed {
    logic wrEn;    // write current MAC word
    logic commit;  // that word closes the packet
    logic pop;     // reader takes head word
    logic snap;    // save pointers on a counted drop
  } strobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_KEEP,
    ST_SKIP
  } rxState_t;

  localparam logic [2:0] REG_MISS  = 3'd0;
  localparam logic [2:0] REG_CAUSE = 3'd1;
  localparam logic [2:0] REG_CTRL  = 3'd2;
  localparam logic [2:0] REG_OCC   = 3'd3;
  localparam logic [2:0] REG_HEAD  = 3'd4;
  localparam logic [2:0] REG_TAIL  = 3'd5;
  localparam logic [2:0] REG_SHEAD = 3'd6;
  localparam logic [2:0] REG_STAIL = 3'd7;

endpackage

// File: rtl/rx_pkt_store_dp.sv
module rx_pkt_store_dp
  import rx_pkt_store_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEop,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEop,
  output logic [PTR_W-1:0]  freeWords,
  output logic [PTR_W-1:0]  pktCount,
  output logic [ADDR_W-1:0] headPtr,
  output logic [ADDR_W-1:0] tailPtr,
  output logic [ADDR_W-1:0] savedHead,
  output logic [ADDR_W-1:0] savedTail
);

  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [DATA_W:0]    mem [DEPTH];
  logic [PTR_W-1:0]   wrWork;
  logic [PTR_W-1:0]   wrTail;
  logic [PTR_W-1:0]   rdPtr;
  logic [PTR_W-1:0]   usedWords;
  logic               popEop;

  assign usedWords = wrWork - rdPtr;
  assign freeWords = DEPTH_P - usedWords;
  assign rdData    = mem[rdPtr[ADDR_W-1:0]][DATA_W-1:0];
  assign rdEop     = mem[rdPtr[ADDR_W-1:0]][DATA_W];
  assign popEop    = stb.pop && rdEop;
  assign headPtr   = rdPtr[ADDR_W-1:0];
  assign tailPtr   = wrTail[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrWork[ADDR_W-1:0]] <= {wrEop, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrWork    <= '0;
      wrTail    <= '0;
      rdPtr     <= '0;
      pktCount  <= '0;
      savedHead <= '0;
      savedTail <= '0;
    end else begin
      if (stb.wrEn)   wrWork <= wrWork + 1'b1;
      if (stb.commit) wrTail <= wrWork + 1'b1;
      if (stb.pop)    rdPtr  <= rdPtr + 1'b1;
      if (stb.commit && !popEop)      pktCount <= pktCount + 1'b1;
      else if (popEop && !stb.commit) pktCount <= pktCount - 1'b1;
      if (stb.snap) begin
        savedHead <= rdPtr[ADDR_W-1:0];
        savedTail <= wrTail[ADDR_W-1:0];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> (usedWords < DEPTH_P)) else $error("word store overrun"); // R1
  AST_POP_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> (pktCount != '0)) else $error("pop without packet"); // R9
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pktCount <= DEPTH_P) else $error("packet count beyond depth"); // R9
  AST_TAIL_STILL: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> (wrTail == $past(wrTail))) else $error("tail moved"); // R2

endmodule

// File: rtl/rx_pkt_store_ctrl.sv
module rx_pkt_store_ctrl
  import rx_pkt_store_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LEN_W  = 12,
  parameter int MISS_W = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              wrSop,
  input  logic              wrEop,
  input  logic [LEN_W-1:0]  wrLen,
  input  logic              rdPop,
  input  logic [2:0]        regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [1:0]        regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  output strobes_t          stb,
  input  logic [PTR_W-1:0]  freeWords,
  input  logic [PTR_W-1:0]  pktCount,
  input  logic [ADDR_W-1:0] headPtr,
  input  logic [ADDR_W-1:0] tailPtr,
  input  logic [ADDR_W-1:0] savedHead,
  input  logic [ADDR_W-1:0] savedTail
);

  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  rxState_t          state, stateNxt;
  logic              rxEn, irqMask;
  logic              causeOvr;
  logic [MISS_W-1:0] missCnt, missBase;
  logic              sopIdle, fits, accept, dropHit;
  logic              missRd, causeClr;

  assign sopIdle = (state == ST_IDLE) && wrValid && wrSop;
  assign fits    = 32'(wrLen) <= 32'(freeWords);
  assign accept  = sopIdle && rxEn && fits;
  assign dropHit = sopIdle && rxEn && !fits;

  always_comb begin
    stb.wrEn   = accept || ((state == ST_KEEP) && wrValid);
    stb.commit = stb.wrEn && wrEop;
    stb.pop    = rdPop && (pktCount != '0);
    stb.snap   = dropHit;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (sopIdle && !wrEop) stateNxt = accept ? ST_KEEP : ST_SKIP;
      ST_KEEP, ST_SKIP: if (wrValid && wrEop) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign missRd   = regRd && (regAddr == REG_MISS);
  assign causeClr = (regRd && (regAddr == REG_CAUSE)) ||
                    (regWr && (regAddr == REG_CAUSE) && regWdata[0]);
  assign missBase = missRd ? '0 : missCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rxEn     <= 1'b0;
      irqMask  <= 1'b0;
      causeOvr <= 1'b0;
      missCnt  <= '0;
    end else begin
      state <= stateNxt;
      if (regWr && (regAddr == REG_CTRL)) begin
        rxEn    <= regWdata[0];
        irqMask <= regWdata[1];
      end
      if (dropHit)       causeOvr <= 1'b1;
      else if (causeClr) causeOvr <= 1'b0;
      if (dropHit && (missBase != MISS_MAX)) missCnt <= missBase + 1'b1;
      else                                   missCnt <= missBase;
    end
  end

  assign irq = causeOvr && irqMask;

  always_comb begin
    case (regAddr)
      REG_MISS:  regRdata = 32'(missCnt);
      REG_CAUSE: regRdata = {31'd0, causeOvr};
      REG_CTRL:  regRdata = {30'd0, irqMask, rxEn};
      REG_OCC:   regRdata = 32'(pktCount);
      REG_HEAD:  regRdata = 32'(headPtr);
      REG_TAIL:  regRdata = 32'(tailPtr);
      REG_SHEAD: regRdata = 32'(savedHead);
      default:   regRdata = 32'(savedTail);
    endcase
  end

  AST_DROP_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    dropHit |=> causeOvr) else $error("drop without cause"); // R3
  AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rstN)
    (dropHit && !missRd && (missCnt != MISS_MAX)) |=> (missCnt == $past(missCnt) + 1'b1))
    else $error("drop not counted"); // R2
  AST_OFF_COUNT_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEn && !missRd) |=> $stable(missCnt)) else $error("count moved while off"); // R4
  AST_OFF_CAUSE_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEn && !causeOvr) |=> !causeOvr) else $error("cause set while off"); // R4
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    ((missCnt == MISS_MAX) && !missRd) |=> (missCnt == MISS_MAX)) else $error("counter wrapped"); // R5
  AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !stb.wrEn) else $error("write in discard"); // R2

endmodule

// File: rtl/rx_pkt_store.sv
module rx_pkt_store
  import rx_pkt_store_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int LEN_W  = 12,
  parameter int MISS_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              wrSop,
  input  logic              wrEop,
  input  logic [LEN_W-1:0]  wrLen,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdPop,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEop,
  input  logic [2:0]        regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [1:0]        regWdata,
  output logic [31:0]       regRdata,
  output logic              irq
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;

  strobes_t          stb;
  logic [PTR_W-1:0]  freeWords, pktCount;
  logic [ADDR_W-1:0] headPtr, tailPtr, savedHead, savedTail;

  assign rdValid = (pktCount != '0);

  rx_pkt_store_ctrl #(
    .DEPTH(DEPTH), .LEN_W(LEN_W), .MISS_W(MISS_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrSop(wrSop), .wrEop(wrEop), .wrLen(wrLen),
    .rdPop(rdPop),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .stb(stb),
    .freeWords(freeWords), .pktCount(pktCount),
    .headPtr(headPtr), .tailPtr(tailPtr),
    .savedHead(savedHead), .savedTail(savedTail)
  );

  rx_pkt_store_dp #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrData(wrData), .wrEop(wrEop),
    .rdData(rdData), .rdEop(rdEop),
    .freeWords(freeWords), .pktCount(pktCount),
    .headPtr(headPtr), .tailPtr(tailPtr),
    .savedHead(savedHead), .savedTail(savedTail)
  );

endmodule

// File: tb/rx_pkt_store_test.sv
module rx_pkt_store_test;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int LEN_W  = 8;
  localparam int MISS_W = 3;

  logic              clk = 1'b0;
  logic              rstN;
  logic              wrValid, wrSop, wrEop;
  logic [LEN_W-1:0]  wrLen;
  logic [DATA_W-1:0] wrData;
  logic              rdPop, rdValid, rdEop;
  logic [DATA_W-1:0] rdData;
  logic [2:0]        regAddr;
  logic              regRd, regWr;
  logic [1:0]        regWdata;
  logic [31:0]       regRdata;
  logic              irq;

  int nChk = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  rx_pkt_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W), .MISS_W(MISS_W)) uut (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrSop(wrSop), .wrEop(wrEop), .wrLen(wrLen), .wrData(wrData),
    .rdPop(rdPop), .rdValid(rdValid), .rdData(rdData), .rdEop(rdEop),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendPkt(input int n, input int declared, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrValid = 1'b1; wrSop = (i == 0); wrEop = (i == n - 1);
      wrLen = LEN_W'(declared); wrData = base + 32'(i);
    end
    @(negedge clk);
    wrValid = 1'b0; wrSop = 1'b0; wrEop = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 v = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [1:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic popPkt(input string req, input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      chk(req, {rdValid, rdEop, rdData[29:0]},
          {1'b1, (i == n - 1), 30'(base + 32'(i))});
      rdPop = 1'b1;
    end
    @(negedge clk);
    rdPop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R9 rdValid after reset", 32'(rdValid), 0);
    chk("R8 irq after reset", 32'(irq), 0);
    for (int a = 0; a < 8; a++) begin
      regRead(3'(a), v);
      chk("R10 register zero after reset", v, 0);
    end
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    sendPkt(3, 3, 32'h50);
    regRead(3'd3, v); chk("R4 no packet stored while off", v, 0);
    regRead(3'd0, v); chk("R4 counter still while off", v, 0);
    regRead(3'd1, v); chk("R4 cause still while off", v, 0);
    regRead(3'd5, v); chk("R4 tail still while off", v, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    regWrite(3'd2, 2'b11);
    sendPkt(4, 4, 32'h100);
    regRead(3'd3, v); chk("R9 one packet stored", v, 1);
    regRead(3'd5, v); chk("R10 tail after 4 words", v, 4);
    sendPkt(2, 2, 32'h200);
    regRead(3'd3, v); chk("R9 two packets stored", v, 2);
    popPkt("R1 first packet words", 4, 32'h100);
    regRead(3'd3, v); chk("R9 count after pop", v, 1);
    regRead(3'd4, v); chk("R10 head after pop", v, 4);
    popPkt("R1 second packet words", 2, 32'h200);
    sendPkt(1, 1, 32'h300);
    popPkt("R1 one-word packet", 1, 32'h300);
    #1 chk("R9 rdValid low when empty", 32'(rdValid), 0);
    regRead(3'd4, v); chk("R10 head after single", v, 7);
  endtask

  task automatic t_drop();
    logic [31:0] v;
    sendPkt(10, 10, 32'h400);
    regRead(3'd5, v); chk("R10 tail wraps", v, 1);
    sendPkt(7, 7, 32'h500);
    regRead(3'd5, v); chk("R2 tail unchanged on drop", v, 1);
    regRead(3'd3, v); chk("R2 no packet stored on drop", v, 1);
    #1 chk("R8 irq with cause and mask", 32'(irq), 1);
    regRead(3'd6, v); chk("R10 saved head", v, 7);
    regRead(3'd7, v); chk("R10 saved tail", v, 1);
    sendPkt(6, 6, 32'h600);
    regRead(3'd3, v); chk("R1 exact fit stored", v, 2);
    regRead(3'd0, v); chk("R2 one drop counted", v, 1);
    regRead(3'd0, v); chk("R6 counter cleared by read", v, 0);
    regRead(3'd1, v); chk("R3 cause set by drop", v, 1);
    regRead(3'd1, v); chk("R7 cause cleared by read", v, 0);
    #1 chk("R8 irq low after clear", 32'(irq), 0);
    popPkt("R1 wrapped packet", 10, 32'h400);
    popPkt("R1 fitted packet", 6, 32'h600);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    sendPkt(17, 17, 32'h700);
    regWrite(3'd1, 2'b00);
    regWrite(3'd2, 2'b01);
    #1 chk("R8 irq masked", 32'(irq), 0);
    regWrite(3'd2, 2'b11);
    #1 chk("R8 irq unmasked", 32'(irq), 1);
    regRead(3'd1, v); chk("R7 zero write keeps cause", v, 1);
    sendPkt(17, 17, 32'h700);
    regWrite(3'd1, 2'b01);
    #1 chk("R7 write one clears irq", 32'(irq), 0);
    regRead(3'd1, v); chk("R7 write one clears cause", v, 0);
  endtask

  task automatic t_sat();
    logic [31:0] v;
    for (int k = 0; k < 7; k++) sendPkt(17, 17, 32'h800);
    regRead(3'd0, v); chk("R5 counter saturated", v, 7);
  endtask

  task automatic t_race();
    logic [31:0] v;
    for (int i = 0; i < 17; i++) begin
      @(negedge clk);
      wrValid = 1'b1; wrSop = (i == 0); wrEop = (i == 16);
      wrLen = 8'd17; wrData = 32'h900 + 32'(i);
      if (i == 0) begin
        regAddr = 3'd0; regRd = 1'b1;
        #1 chk("R6 old value on racing read", regRdata, 0);
      end else regRd = 1'b0;
    end
    @(negedge clk);
    wrValid = 1'b0; wrSop = 1'b0; wrEop = 1'b0;
    regRead(3'd0, v); chk("R6 racing drop kept", v, 1);
  endtask

  task automatic midPkt(input logic [31:0] base, input logic [1:0] ctrlVal);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      wrValid = 1'b1; wrSop = (i == 0); wrEop = (i == 2);
      wrLen = 8'd3; wrData = base + 32'(i);
      regWr = (i == 1); regAddr = 3'd2; regWdata = ctrlVal;
    end
    @(negedge clk);
    wrValid = 1'b0; wrSop = 1'b0; wrEop = 1'b0; regWr = 1'b0;
  endtask

  task automatic t_midEnable();
    logic [31:0] v;
    regWrite(3'd2, 2'b01);
    midPkt(32'hA00, 2'b00);
    regRead(3'd3, v); chk("R11 disable mid packet keeps it", v, 1);
    midPkt(32'hB00, 2'b01);
    regRead(3'd3, v); chk("R11 enable mid packet no store", v, 1);
    regRead(3'd0, v); chk("R11 enable mid packet no count", v, 0);
    popPkt("R11 kept packet data", 3, 32'hA00);
  endtask

  initial begin
    rstN = 1'b0; wrValid = 1'b0; wrSop = 1'b0; wrEop = 1'b0; wrLen = '0; wrData = '0;
    rdPop = 1'b0; regAddr = '0; regRd = 1'b0; regWr = 1'b0; regWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_disabled();
    t_basic();
    t_drop();
    t_w1c();
    t_sat();
    t_race();
    t_midEnable();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule